// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an eight-pin general-purpose I/O port on an APB slave. A direction register selects, pin by pin, whether the port drives that pin (bit set) or only samples it (bit clear). The output-enable vector follows the direction register. The pin output vector follows the output data register.

The data register is aliased across a window of 256 words. For every data access, the word-address bits of the bus address form an eight-bit pin mask. A write changes only the pins whose mask bit is set, so software can set or clear one pin without reading first. A read returns zero in every unmasked position. Input pins pass through a two-flop synchroniser before they can be read. Output pins read back the value being driven. Transfers complete with no wait states.

A small bus-phase state machine qualifies every transfer. It has two states:
- `BUS_IDLE`: no setup phase was seen in the previous cycle.
- `BUS_ACCESS`: the previous cycle was a setup phase, so the current cycle may complete a transfer.

Its transitions are:
- *setup seen*: `BUS_IDLE` to `BUS_ACCESS`, taken on select high with enable low.
- *transfer done*: `BUS_ACCESS` to `BUS_IDLE`, taken on anything else.
- *re-setup*: `BUS_ACCESS` to `BUS_ACCESS`, taken when a fresh setup phase follows directly.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset the direction register and the output data register are zero, so `pin_oe` = 0x00 and `pin_out` = 0x00, and reading the direction register returns 0.
- R2: `pready` is always 1 and `pslverr` is always 0, so every transfer ends in its first access cycle.
- R3: The direction register is at byte offset 0x400 (bit 1 = output, bit 0 = input). A write there stores `pwdata[7:0]` and ignores `pwdata[31:8]`. A read returns the stored byte in `prdata[7:0]` with `prdata[31:8]` = 0. `pin_oe` equals the stored byte from the cycle after the write.
- R4: A write to any offset in 0x000..0x3FC updates output data bit j from `pwdata[j]` only where `paddr[j+2]` = 1. All other bits keep their value. `pin_out` equals the output data register.
- R5: A read from offset 0x000..0x3FC returns 0 in every bit j where `paddr[j+2]` = 0.
- R6: For a pin whose direction bit is 0, a data read returns the pin level sampled through two flops. A change of `pin_in` is first visible to a read whose access cycle follows the second rising edge after the change.
- R7: For a pin whose direction bit is 1, a masked data read returns the output data register bit, not `pin_in`.
- R8: Reads from offsets outside 0x000..0x3FC and 0x400 (for example 0x404 and 0x800) return 0, and writes to them change neither register.
- R9: A cycle with `psel` and `penable` high that was not preceded by a setup cycle (select high, enable low) has no effect. `prdata` is 0 in every cycle that is not a read access cycle.
- R10: Offset 1 << (n+2) reads or writes pin n alone: a write there changes only pin n, and a read returns that pin's bit in position n with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits [9:2] form the data mask |
| pwdata | input | 32 | Write data; only [7:0] used |
| prdata | output | 32 | Read data; [31:8] always 0 |
| pready | output | 1 | Transfer complete, held 1 |
| pslverr | output | 1 | Transfer error, held 0 |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
Register writes take effect at the rising edge that closes the access cycle. The bench therefore checks `pin_out` and `pin_oe` one time step after that edge.

Read data is combinational during the access cycle. A monitor samples it on the falling edge of that cycle and pops the expected value that the driver queued before the setup cycle.

Input synchronisation adds two edges. One read therefore changes `pin_in` together with its setup cycle, which leaves one edge before the access cycle, and expects the old level. The next read expects the new level. Other pin changes are followed by three idle clocks before any read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int GPIO_PINS   = 8;
    localparam int GPIO_MASK_LO = 2;

    typedef enum logic [0:0] {
        BUS_IDLE   = 1'b0,
        BUS_ACCESS = 1'b1
    } bus_state_e;
endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_stb
);
    bus_state_e state_q;
    bus_state_e state_d;
    logic       setup_now;

    assign setup_now = psel && !penable;

    always_comb begin
        state_d = BUS_IDLE;
        unique case (state_q)
            BUS_IDLE:   if (setup_now) state_d = BUS_ACCESS;
            BUS_ACCESS: if (setup_now) state_d = BUS_ACCESS;
            default:    state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        if (state_q == BUS_ACCESS && psel && penable) begin
            wr_stb = pwrite;
            rd_stb = !pwrite;
        end
    end

    AST_ACCESS_NEEDS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_ACCESS) |-> $past(psel && !penable)); // R9
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb)); // R9
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[b] <= 1'b0;
                sync_q[b] <= 1'b0;
            end else begin
                meta_q[b] <= din[b];
                sync_q[b] <= meta_q[b];
            end
        end
    end

    assign dout = sync_q;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (dout == $past(din, 2))); // R6
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PINS       = GPIO_PINS,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PINS-1:0]   wbyte,
    input  logic [PINS-1:0]   pins_sync,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   rbyte
);
    localparam int MASK_HI = GPIO_MASK_LO + PINS - 1;
    localparam int WORD_W  = ADDR_W - GPIO_MASK_LO;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(DIR_OFFSET >> GPIO_MASK_LO);

    logic [PINS-1:0] mask;
    logic            data_sel;
    logic            dir_sel;
    logic [PINS-1:0] live;

    assign mask     = addr[MASK_HI:GPIO_MASK_LO];
    assign data_sel = (addr[ADDR_W-1:MASK_HI+1] == '0);
    assign dir_sel  = (addr[ADDR_W-1:GPIO_MASK_LO] == DIR_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 dir_q <= '0;
        else if (wr_stb && dir_sel) dir_q <= wbyte;
    end

    for (genvar j = 0; j < PINS; j++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               out_q[j] <= 1'b0;
            else if (wr_stb && data_sel && mask[j])   out_q[j] <= wbyte[j];
        end
        assign live[j] = dir_q[j] ? out_q[j] : pins_sync[j];
    end

    always_comb begin
        rbyte = '0;
        if (rd_stb) begin
            if (data_sel)     rbyte = live & mask;
            else if (dir_sel) rbyte = dir_q;
        end
    end

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && dir_sel) |=> $stable(dir_q)); // R3
    AST_OUT_UNSEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && data_sel) |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask)))); // R4
    AST_OUT_SEL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && data_sel) |=> ((out_q & $past(mask)) == ($past(wbyte) & $past(mask)))); // R4
    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !data_sel && !dir_sel) |=> ($stable(out_q) && $stable(dir_q))); // R8
    AST_RD_UNSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && data_sel) |-> ((rbyte & ~mask) == '0)); // R5
    AST_RD_OUTPUT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && data_sel) |-> (((rbyte ^ out_q) & dir_q & mask) == '0)); // R7
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [GPIO_PINS-1:0] pin_in,
    output logic [GPIO_PINS-1:0] pin_out,
    output logic [GPIO_PINS-1:0] pin_oe
);
    logic                 wr_stb;
    logic                 rd_stb;
    logic [GPIO_PINS-1:0] pins_sync;
    logic [GPIO_PINS-1:0] rbyte;

    gpio_bus_fsm u_fsm (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb)
    );

    gpio_in_sync #(.WIDTH(GPIO_PINS)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .din   (pin_in),
        .dout  (pins_sync)
    );

    gpio_port_regs #(
        .ADDR_W     (ADDR_W),
        .PINS       (GPIO_PINS),
        .DIR_OFFSET (DIR_OFFSET)
    ) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .addr      (paddr),
        .wbyte     (pwdata[GPIO_PINS-1:0]),
        .pins_sync (pins_sync),
        .dir_q     (pin_oe),
        .out_q     (pin_out),
        .rbyte     (rbyte)
    );

    assign prdata  = {{(DATA_W-GPIO_PINS){1'b0}}, rbyte};
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    AST_IDLE_PRDATA_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable && !pwrite) |-> (prdata == '0)); // R9
endmodule

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit rd_active = 1'b0;
    bit done = 1'b0;

    typedef struct { logic [31:0] v; string tag; } exp_t;
    exp_t sb_q[$];

    logic [7:0] m_dir = '0, m_out = '0;

    always #4 clk = ~clk;

    gpio_mask_port dut_i (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_data(input logic [11:0] a, input logic [7:0] pins);
        return a[9:2] & ((m_dir & m_out) | (~m_dir & pins));
    endfunction

    // Monitor: pop on each read access cycle
    always @(negedge clk) begin
        if (rd_active && psel && penable && !pwrite) begin
            chk("R2 pready", {31'd0, pready}, 32'd1);
            chk("R2 pslverr", {31'd0, pslverr}, 32'd0);
            if (sb_q.size() == 0) begin
                chk("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, prdata, e.v);
            end
        end
    end

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
        if (a[11:10] == 2'b00) m_out = (m_out & ~a[9:2]) | (d[7:0] & a[9:2]);
        else if (a == 12'h400) m_dir = d[7:0];
    endtask

    task automatic apb_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.v = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = a; rd_active = 1;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0; rd_active = 0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pin_out reset", {24'd0, pin_out}, 32'h0);
        chk("R1 pin_oe reset", {24'd0, pin_oe}, 32'h0);
        rst_n = 1;
        apb_read(12'h400, 32'h0, "R1 dir read after reset");

        // R3: direction register, upper data ignored
        apb_write(12'h400, 32'hABCD_12F0);
        chk("R3 pin_oe", {24'd0, pin_oe}, 32'hF0);
        apb_read(12'h400, 32'h0000_00F0, "R3 dir readback");

        // R4: full-mask then partial-mask writes
        apb_write(12'h3FC, 32'hFFFF_FFA5);
        chk("R4 full write", {24'd0, pin_out}, 32'hA5);
        apb_write(12'h03C, 32'h0);
        chk("R4 masked write", {24'd0, pin_out}, 32'hA0);

        // R10: single-pin writes
        apb_write(12'h100, 32'h40);
        chk("R10 set pin6", {24'd0, pin_out}, 32'hE0);
        apb_write(12'h200, 32'h00);
        chk("R10 clear pin7", {24'd0, pin_out}, 32'h60);

        // R6/R7/R5 reads with stable pins
        pin_in = 8'h3C;
        repeat (3) @(posedge clk);
        apb_read(12'h3FC, {24'd0, exp_data(12'h3FC, 8'h3C)}, "R7 full read mixed dirs");
        apb_read(12'h030, {24'd0, exp_data(12'h030, 8'h3C)}, "R6 masked input read");
        apb_read(12'h00C, 32'h0, "R5 unmasked bits zero");
        apb_read(12'h080, 32'h20, "R10 single pin5 read");
        apb_read(12'h300, 32'h40, "R7 output pins ignore pin_in");

        // R6 latency: pin change coincides with setup cycle
        begin
            exp_t it;
            it.v = {24'd0, exp_data(12'h03C, 8'h3C)}; it.tag = "R6 old level before sync";
            sb_q.push_back(it);
            @(posedge clk); #1;
            psel = 1; penable = 0; pwrite = 0; paddr = 12'h03C; rd_active = 1; pin_in = 8'h05;
            @(posedge clk); #1;
            penable = 1;
            @(posedge clk); #1;
            psel = 0; penable = 0; rd_active = 0;
        end
        apb_read(12'h03C, {24'd0, exp_data(12'h03C, 8'h05)}, "R6 new level after sync");

        // R8: unmapped offsets
        apb_write(12'h800, 32'hFF);
        apb_write(12'h404, 32'hFF);
        chk("R8 pin_out unchanged", {24'd0, pin_out}, 32'h60);
        chk("R8 pin_oe unchanged", {24'd0, pin_oe}, 32'hF0);
        apb_read(12'h800, 32'h0, "R8 read 0x800");
        apb_read(12'h404, 32'h0, "R8 read 0x404");

        // R9: enable without setup is ignored
        @(posedge clk); #1;
        psel = 1; penable = 1; pwrite = 1; paddr = 12'h3FC; pwdata = 32'h0;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
        chk("R9 unqualified write ignored", {24'd0, pin_out}, 32'h60);
        // R9: prdata zero during setup cycle of a read
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = 0; paddr = 12'h3FC;
        @(negedge clk);
        chk("R9 prdata zero in setup", prdata, 32'h0);
        @(posedge clk); #1;
        psel = 0;

        // R6: all pins inputs after clearing direction
        apb_write(12'h400, 32'h00);
        chk("R3 pin_oe cleared", {24'd0, pin_oe}, 32'h00);
        apb_read(12'h3FC, 32'h05, "R6 all-input read");

        repeat (2) @(posedge clk);
        chk("scoreboard drained", sb_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule